// File: doc/BRIEF.md
# Debug Trace Trigger Controller

This block runs one debug capture at a time for a small on-chip trace buffer. Configuration bits set the trigger mode, the capture style (begin or end), and the read/write qualifiers. These bits come from a register block outside this design. Two comparator hit lines, A and B, arrive from external address/data comparators. The controller combines them according to the selected mode. From the result it decides which bus cycles write an entry into an 8-deep, 16-bit trace store and when the run finishes.

In normal modes the stored entries are change-of-flow addresses. In the two event-only modes, each qualified B event stores the bus data byte instead, zero-extended to 16 bits. Debug software reads the buffer back through an index input, where index 0 is the oldest entry. Status outputs report the armed state, the sticky A and B match flags and the entry count.

Top module: `trace_trigger_ctrl`

## Requirements
- R1: After synchronous reset, `armed`, `flag_a`, `flag_b` and `count` are all 0.
- R2: A cycle with `arm_start`=1, `en`=1 and `arm_stop`=0 makes `armed`=1 and clears `flag_a`, `flag_b` and `count` on the next clock. When `en`=0, `arm_start` has no effect.
- R3: `arm_stop`=1 or `en`=0 clears `armed` on the next clock. No entry is stored in that cycle, and `count` holds while disarmed.
- R4: Inputs are used only in cycles with `bus_valid`=1. The qualified hits qa and qb are combined by `trig_mode` as follows:
  - 0: qa
  - 1: qa|qb
  - 2: B after A
  - 3: qb as an event
  - 4: qb after A as an event
  - 5: qa&qb (A address with B data)
  - 6: qa&!qb
  - 7: qa&qb inside a range, where A reports address≥low and B reports address≤high
  - 8: !(qa&qb) outside that range
  - 9 to 15: behave as mode 0.
- R5: When `rwa_en`=1, the A hit counts only if `bus_rw` equals `rwa_val`. B is qualified the same way with `rwb_en` and `rwb_val`.
- R6: In modes 2 and 4, a B hit is ignored, for both the trigger and `flag_b`, until `flag_a` is set. `flag_a` then stays set until the next arming.
- R7: While armed, `flag_a` and `flag_b` are set by a qualified A or B hit and stay set until re-armed.
- R8: Begin capture (`begin_sel`=1, non-event mode) stores `cof_addr` on each `cof_valid` from the trigger cycle on. The run ends (`armed`=0) on the clock that stores the 8th entry.
- R9: End capture (`begin_sel`=0, non-event mode) stores `cof_addr` on every `cof_valid` from arming. The trigger cycle's address is included. `count` saturates at 8 while the oldest entries are overwritten, and the run ends on the trigger.
- R10: Event modes (3, 4) ignore `begin_sel` and `cof_valid`. They store {8'h00, `bus_data`} per event and end when 8 entries are held.
- R11: `rd_data` returns, combinationally, entry `rd_idx` counted from the oldest held entry (index 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable level |
| arm_start | input | 1 | Pulse: arm written with 1 |
| arm_stop | input | 1 | Pulse: arm written with 0 |
| trig_mode | input | 4 | Trigger mode encoding |
| begin_sel | input | 1 | 1 = begin capture, 0 = end capture |
| rwa_en | input | 1 | Enable R/W qualification of A |
| rwa_val | input | 1 | R/W value A must see |
| rwb_en | input | 1 | Enable R/W qualification of B |
| rwb_val | input | 1 | R/W value B must see |
| bus_valid | input | 1 | Bus cycle with valid hit lines |
| bus_rw | input | 1 | Bus read/write level of this cycle |
| match_a | input | 1 | Comparator A hit |
| match_b | input | 1 | Comparator B hit |
| bus_data | input | 8 | Data byte for event modes |
| cof_valid | input | 1 | Change-of-flow address strobe |
| cof_addr | input | 16 | Change-of-flow address |
| rd_idx | input | 3 | Read index, 0 = oldest |
| armed | output | 1 | Run in progress |
| flag_a | output | 1 | Sticky A match flag |
| flag_b | output | 1 | Sticky B match flag |
| count | output | 4 | Entries held, 0 to 8 |
| rd_data | output | 16 | Entry at `rd_idx` |

## Verification
The assertions assume that `trig_mode` and the other configuration inputs change only while the block is disarmed. Without that, the sequence-mode check on `flag_b` could be fooled by a mode change in the middle of a run. They also assume `arm_start` is a single-cycle pulse. The stimulus follows both rules: it sets the configuration and then arms, and it drives every strobe for exactly one clock before returning it to 0. Range and data modes are exercised purely through the A/B hit levels, since the comparators themselves sit outside the block.

// File: rtl/trace_trig_pkg.sv
package trace_trig_pkg;

    typedef enum logic [3:0] {
        MODE_A_ONLY      = 4'd0,
        MODE_A_OR_B      = 4'd1,
        MODE_A_THEN_B    = 4'd2,
        MODE_EVT_B       = 4'd3,
        MODE_A_THEN_EVT  = 4'd4,
        MODE_A_AND_BDATA = 4'd5,
        MODE_A_NOT_BDATA = 4'd6,
        MODE_IN_RANGE    = 4'd7,
        MODE_OUT_RANGE   = 4'd8
    } trig_mode_e;

    typedef struct packed {
        logic qa;
        logic qb;
    } qual_hits_t;

    typedef struct packed {
        logic trig;
        logic evt;
        logic seq;
    } mode_res_t;

    // Unused encodings fall back to A-only
    function automatic trig_mode_e decode_mode(input logic [3:0] raw);
        if (raw > 4'd8) return MODE_A_ONLY;
        return trig_mode_e'(raw);
    endfunction

    function automatic logic rw_ok(input logic rw_en, input logic rw_val, input logic rw);
        return !rw_en || (rw == rw_val);
    endfunction

endpackage

// File: rtl/trig_mode_logic.sv
module trig_mode_logic
    import trace_trig_pkg::*;
(
    input  logic       bus_valid,
    input  logic       bus_rw,
    input  logic       match_a,
    input  logic       match_b,
    input  logic       rwa_en,
    input  logic       rwa_val,
    input  logic       rwb_en,
    input  logic       rwb_val,
    input  logic [3:0] mode_raw,
    input  logic       seen_a,
    output qual_hits_t hits,
    output mode_res_t  res
);
    trig_mode_e mode;

    always_comb begin
        mode    = decode_mode(mode_raw);
        hits.qa = bus_valid && match_a && rw_ok(rwa_en, rwa_val, bus_rw);
        hits.qb = bus_valid && match_b && rw_ok(rwb_en, rwb_val, bus_rw);
        res.evt = (mode == MODE_EVT_B) || (mode == MODE_A_THEN_EVT);
        res.seq = (mode == MODE_A_THEN_B) || (mode == MODE_A_THEN_EVT);
        case (mode)
            MODE_A_OR_B:      res.trig = hits.qa || hits.qb;
            MODE_A_THEN_B:    res.trig = seen_a && hits.qb;
            MODE_EVT_B:       res.trig = hits.qb;
            MODE_A_THEN_EVT:  res.trig = seen_a && hits.qb;
            MODE_A_AND_BDATA: res.trig = hits.qa && hits.qb;
            MODE_A_NOT_BDATA: res.trig = hits.qa && !hits.qb;
            MODE_IN_RANGE:    res.trig = hits.qa && hits.qb;
            MODE_OUT_RANGE:   res.trig = bus_valid && !(hits.qa && hits.qb);
            default:          res.trig = hits.qa;
        endcase
    end
endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (count != CNT_W'(DEPTH)) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst && !clr) mem[wr_ptr] <= wr_data;
    end

    // Oldest entry sits count places behind the write pointer
    always_comb begin
        rd_ptr  = wr_ptr - IDX_W'(count) + rd_idx;
        rd_data = mem[rd_ptr];
    end
endmodule

// File: rtl/trace_trigger_ctrl.sv
module trace_trigger_ctrl
    import trace_trig_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              arm_start,
    input  logic              arm_stop,
    input  logic [3:0]        trig_mode,
    input  logic              begin_sel,
    input  logic              rwa_en,
    input  logic              rwa_val,
    input  logic              rwb_en,
    input  logic              rwb_val,
    input  logic              bus_valid,
    input  logic              bus_rw,
    input  logic              match_a,
    input  logic              match_b,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              cof_valid,
    input  logic [ADDR_W-1:0] cof_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              armed,
    output logic              flag_a,
    output logic              flag_b,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] rd_data
);
    qual_hits_t        hits;
    mode_res_t         res;
    logic              trg_seen;
    logic              begin_eff;
    logic              stopping;
    logic              starting;
    logic              store;
    logic [ADDR_W-1:0] store_data;

    trig_mode_logic u_mode (
        .bus_valid (bus_valid),
        .bus_rw    (bus_rw),
        .match_a   (match_a),
        .match_b   (match_b),
        .rwa_en    (rwa_en),
        .rwa_val   (rwa_val),
        .rwb_en    (rwb_en),
        .rwb_val   (rwb_val),
        .mode_raw  (trig_mode),
        .seen_a    (flag_a),
        .hits      (hits),
        .res       (res)
    );

    always_comb begin
        stopping   = !en || arm_stop;
        starting   = !stopping && arm_start;
        begin_eff  = res.evt || begin_sel;
        store      = armed && !stopping && !arm_start &&
                     (res.evt ? res.trig
                              : (cof_valid && (!begin_eff || trg_seen || res.trig)));
        store_data = res.evt ? ADDR_W'(bus_data) : cof_addr;
    end

    trace_store #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (starting),
        .wr_en   (store),
        .wr_data (store_data),
        .rd_idx  (rd_idx),
        .count   (count),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            flag_a   <= 1'b0;
            flag_b   <= 1'b0;
            trg_seen <= 1'b0;
        end else if (stopping) begin
            armed <= 1'b0;
        end else if (arm_start) begin
            armed    <= 1'b1;
            flag_a   <= 1'b0;
            flag_b   <= 1'b0;
            trg_seen <= 1'b0;
        end else if (armed) begin
            if (hits.qa) flag_a <= 1'b1;
            if (hits.qb && (!res.seq || flag_a)) flag_b <= 1'b1;
            if (res.trig) trg_seen <= 1'b1;
            if (!begin_eff && res.trig) armed <= 1'b0;
            if (begin_eff && store && count == CNT_W'(DEPTH - 1)) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/trace_trigger_chk.sv
module trace_trigger_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             arm_start,
    input logic             arm_stop,
    input logic [3:0]       trig_mode,
    input logic             armed,
    input logic             flag_a,
    input logic             flag_b,
    input logic [CNT_W-1:0] count
);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (en && arm_start && !arm_stop) |=> (armed && count == '0 && !flag_a && !flag_b));

    assert_stop_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        (!en || arm_stop) |=> !armed);

    assert_idle_count_R3: assert property (@(posedge clk) disable iff (rst)
        (!armed && !(en && arm_start)) |=> $stable(count));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_seq_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (trig_mode == 4'd2 && !flag_a && !flag_b && !arm_start) |=> !flag_b);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_a && !arm_start) |=> flag_a);
endmodule

bind trace_trigger_ctrl trace_trigger_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .arm_start (arm_start),
    .arm_stop  (arm_stop),
    .trig_mode (trig_mode),
    .armed     (armed),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .count     (count)
);

// File: tb/sim_trace_trigger_ctrl.sv
module sim_trace_trigger_ctrl;
    logic        clk = 1'b0;
    logic        rst, en, arm_start, arm_stop, begin_sel;
    logic [3:0]  trig_mode;
    logic        rwa_en, rwa_val, rwb_en, rwb_val;
    logic        bus_valid, bus_rw, match_a, match_b, cof_valid;
    logic [7:0]  bus_data;
    logic [15:0] cof_addr;
    logic [2:0]  rd_idx;
    logic        armed, flag_a, flag_b;
    logic [3:0]  count;
    logic [15:0] rd_data;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_trigger_ctrl u0 (
        .clk(clk), .rst(rst), .en(en), .arm_start(arm_start), .arm_stop(arm_stop),
        .trig_mode(trig_mode), .begin_sel(begin_sel), .rwa_en(rwa_en), .rwa_val(rwa_val),
        .rwb_en(rwb_en), .rwb_val(rwb_val), .bus_valid(bus_valid), .bus_rw(bus_rw),
        .match_a(match_a), .match_b(match_b), .bus_data(bus_data), .cof_valid(cof_valid),
        .cof_addr(cof_addr), .rd_idx(rd_idx), .armed(armed), .flag_a(flag_a),
        .flag_b(flag_b), .count(count), .rd_data(rd_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic va, input logic ma, input logic mb, input logic rw,
                        input logic cv, input logic [15:0] ad, input logic [7:0] dt);
        bus_valid = va; match_a = ma; match_b = mb; bus_rw = rw;
        cof_valid = cv; cof_addr = ad; bus_data = dt;
        tick();
        bus_valid = 0; match_a = 0; match_b = 0; cof_valid = 0;
    endtask

    task automatic arm();
        arm_start = 1;
        tick();
        arm_start = 0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic [15:0] exp, input string tag);
        rd_idx = idx;
        #1;
        chk(32'(rd_data), 32'(exp), tag);
    endtask

    function automatic logic exp_trig(input int m, input logic a, input logic b);
        case (m)
            1: return a | b;
            2: return 1'b0;
            3: return b;
            4: return 1'b0;
            5: return a & b;
            6: return a & !b;
            7: return a & b;
            8: return !(a & b);
            default: return a;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; en = 1; arm_start = 0; arm_stop = 0; begin_sel = 0; trig_mode = 0;
        rwa_en = 0; rwa_val = 0; rwb_en = 0; rwb_val = 0;
        bus_valid = 0; bus_rw = 0; match_a = 0; match_b = 0; cof_valid = 0;
        bus_data = 0; cof_addr = 0; rd_idx = 0;
        @(negedge clk); tick(); rst = 0;
        // R1 reset state
        chk(armed, 0, "R1 armed"); chk(flag_a, 0, "R1 flag_a");
        chk(flag_b, 0, "R1 flag_b"); chk(count, 0, "R1 count");

        // R4 R7 R10 sweep of every mode and hit pair, end capture
        for (int m = 0; m < 16; m++) begin
            for (int ab = 0; ab < 4; ab++) begin
                logic a, b, t, ev;
                a = ab[1]; b = ab[0];
                trig_mode = 4'(m); begin_sel = 0;
                arm();
                step(1, a, b, 0, 1, 16'h1234, 8'h5A);
                t  = exp_trig(m, a, b);
                ev = (m == 3 || m == 4);
                if (ev) begin
                    chk(count, {3'b0, t}, $sformatf("R10 mode %0d ab %0d count", m, ab));
                    chk(armed, 1, $sformatf("R10 mode %0d ab %0d armed", m, ab));
                end else begin
                    chk(armed, !t, $sformatf("R4 mode %0d ab %0d armed", m, ab));
                    chk(count, 1, $sformatf("R9 mode %0d ab %0d count", m, ab));
                end
                chk(flag_a, a, $sformatf("R7 mode %0d ab %0d flag_a", m, ab));
                chk(flag_b, (m == 2 || m == 4) ? 1'b0 : b,
                    $sformatf("R6 mode %0d ab %0d flag_b", m, ab));
            end
        end

        // R6 sequence: B ignored before A
        trig_mode = 2; begin_sel = 0; arm();
        step(1, 0, 1, 0, 0, 0, 0);
        chk(armed, 1, "R6 B before A armed"); chk(flag_b, 0, "R6 B before A flag_b");
        step(1, 1, 0, 0, 0, 0, 0);
        chk(armed, 1, "R6 A armed"); chk(flag_a, 1, "R6 flag_a set");
        step(1, 0, 0, 0, 0, 0, 0);
        chk(flag_a, 1, "R6 flag_a sticky");
        step(1, 0, 1, 0, 0, 0, 0);
        chk(armed, 0, "R6 B after A ends run"); chk(flag_b, 1, "R6 flag_b after A");

        // R2 re-arm clears flags
        arm();
        chk(armed, 1, "R2 armed"); chk(flag_a, 0, "R2 flag_a clr");
        chk(flag_b, 0, "R2 flag_b clr"); chk(count, 0, "R2 count clr");

        // R5 R/W qualification on A
        trig_mode = 0; rwa_en = 1; rwa_val = 1; arm();
        step(1, 1, 0, 0, 0, 0, 0);
        chk(armed, 1, "R5 wrong rw ignored"); chk(flag_a, 0, "R5 wrong rw flag");
        step(1, 1, 0, 1, 0, 0, 0);
        chk(armed, 0, "R5 right rw triggers");
        rwa_en = 0;
        // R5 on B
        trig_mode = 3; rwb_en = 1; rwb_val = 0; arm();
        step(1, 0, 1, 1, 0, 0, 8'h77);
        chk(count, 0, "R5 B wrong rw no event");
        step(1, 0, 1, 0, 0, 0, 8'h77);
        chk(count, 1, "R5 B right rw event");
        rwb_en = 0;

        // R8 begin capture
        trig_mode = 0; begin_sel = 1; arm();
        step(1, 0, 0, 0, 1, 16'h0100, 0);
        chk(count, 0, "R8 no store before trigger");
        step(1, 1, 0, 0, 1, 16'h0200, 0);
        chk(count, 1, "R8 trigger cycle stored");
        for (int i = 1; i < 8; i++) begin
            step(0, 0, 0, 0, 1, 16'h0200 + 16'(i), 0);
            chk(armed, (i == 7) ? 1'b0 : 1'b1, $sformatf("R8 armed after %0d", i + 1));
        end
        chk(count, 8, "R8 full");
        step(0, 0, 0, 0, 1, 16'hFFFF, 0);
        chk(count, 8, "R3 no store when disarmed");
        for (int i = 0; i < 8; i++) rd(3'(i), 16'h0200 + 16'(i), $sformatf("R11 begin entry %0d", i));

        // R9 end capture wraps
        begin_sel = 0; arm();
        for (int i = 0; i < 11; i++) step(0, 0, 0, 0, 1, 16'h0300 + 16'(i), 0);
        chk(count, 8, "R9 saturated"); chk(armed, 1, "R9 still armed");
        step(1, 1, 0, 0, 1, 16'h030B, 0);
        chk(armed, 0, "R9 ends on trigger");
        for (int i = 0; i < 8; i++) rd(3'(i), 16'h0304 + 16'(i), $sformatf("R9 entry %0d", i));

        // R10 event-only ignores begin_sel and cof
        trig_mode = 3; begin_sel = 0; arm();
        step(1, 1, 0, 0, 1, 16'hAAAA, 8'h99);
        chk(count, 0, "R10 no address store");
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 1, 16'hBBBB, 8'h10 + 8'(i));
        chk(count, 8, "R10 full"); chk(armed, 0, "R10 ends at full");
        for (int i = 0; i < 8; i++) rd(3'(i), 16'h0010 + 16'(i), $sformatf("R10 entry %0d", i));

        // R3 stop by enable low and by arm_stop
        trig_mode = 0; arm();
        step(0, 0, 0, 0, 1, 16'h0001, 0);
        step(0, 0, 0, 0, 1, 16'h0002, 0);
        en = 0;
        step(0, 0, 0, 0, 1, 16'h0003, 0);
        chk(armed, 0, "R3 en low disarms"); chk(count, 2, "R3 en low no store");
        arm();
        chk(armed, 0, "R2 arm ignored with en low"); chk(count, 2, "R2 count kept");
        en = 1; arm();
        arm_stop = 1;
        step(0, 0, 0, 0, 1, 16'h0004, 0);
        arm_stop = 0;
        chk(armed, 0, "R3 arm_stop disarms"); chk(count, 0, "R3 arm_stop no store");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule